// File: doc/BRIEF.md
# SDRAM Command Spacing Monitor

This block sits beside an SDRAM controller and watches, without driving anything, the decoded command stream it sends to a single-data-rate SDRAM. It counts the clocks between related events: the end of a write burst, a mode-register load, the clock-enable level. It sets a sticky bit in a violation vector whenever a command arrives earlier than the device's minimum spacing allows. Each rule owns one bit, so a failing controller can be diagnosed from the vector alone.

The gap from the end of a write burst to the next bank activation depends on the CAS latency, which is a configuration input. The monitor also enforces the power-up sequence. A pause of a parameterised number of clocks must elapse first. Two AUTO REFRESH commands must then be issued before any other command. Idle cycles (NOP or deselect) move every counter forward and can never raise a violation.

Top module: `sdram_cmd_spacing_mon`

## Requirements
- R1: READ and WRITE commands (codes 2 and 3) issued on consecutive clocks, with no write burst ending in the same clock, set no violation bit.
- R2: An ACTIVE (code 1) or REFRESH (code 5) accepted fewer than 2 clocks after an accepted LOAD MODE (code 6) sets violation bit 1.
- R3: A PRECHARGE (code 4) accepted fewer than 2 clocks after a clock with `wr_last_i` high sets violation bit 2; a gap of 0 means the same clock.
- R4: An ACTIVE accepted fewer than CL+2 clocks after a clock with `wr_last_i` high sets violation bit 3. `cl_i` values 1, 2 and 3 give minimum gaps of 3, 4 and 5; the value 0 is treated as 3.
- R5: A BURST STOP (code 7) accepted in the same clock as `wr_last_i` sets violation bit 4; one clock later it is legal.
- R6: A READ or WRITE accepted in the same clock as `wr_last_i` sets violation bit 5.
- R7: Until PAUSE_CYC clocks have passed since reset and two REFRESH commands have then been accepted, any non-NOP command sets violation bit 0. A REFRESH issued before the pause ends is a violation and does not count.
- R8: A non-NOP command in a clock whose preceding clock had `cke_i` low sets violation bit 6 and is otherwise ignored: it is not checked by other rules, does not restart the mode-load timer and does not count as a refresh.
- R9: Violation bits are set at the clock edge that samples the offending command, stay set until reset, are all cleared by reset, and `viol_any_o` is the OR of the bits.
- R10: The NOP code is 0; a NOP, with or without `wr_last_i`, never sets any violation bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the SDRAM interface |
| rst | input | 1 | Synchronous active-high reset |
| cke_i | input | 1 | Clock-enable level driven to the device |
| cmd_i | input | 3 | Decoded command code (0 NOP, 1 ACTIVE, 2 READ, 3 WRITE, 4 PRECHARGE, 5 REFRESH, 6 LOAD MODE, 7 BURST STOP) |
| cl_i | input | 2 | CAS latency setting (1 to 3) |
| wr_last_i | input | 1 | High in the clock of the last write data of a burst |
| viol_o | output | 7 | Sticky per-rule violation bits |
| viol_any_o | output | 1 | High when any violation bit is set |

## Verification
A single ACTIVE can break the mode-load rule and the write-to-activate rule at once. The bench provokes this with a LOAD MODE in the same clock as the last write data, followed directly by an ACTIVE. Both bits 1 and 3 must rise on the same edge, and the reference model predicts each rule separately. The bench also places a LOAD MODE inside a clock-disable window and then an early ACTIVE. Only the clock-enable bit must be set, which shows the ignored command left no timer behind.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5,
    CMD_LMR = 3'd6,
    CMD_BST = 3'd7
  } sdr_cmd_e;

  localparam int RULE_N    = 7;
  localparam int RULE_INIT = 0;
  localparam int RULE_MRD  = 1;
  localparam int RULE_RDL  = 2;
  localparam int RULE_DAL  = 3;
  localparam int RULE_BDL  = 4;
  localparam int RULE_CDL  = 5;
  localparam int RULE_CKE  = 6;

  localparam int MRD_MIN   = 2;
  localparam int RDL_MIN   = 2;
  localparam int DAL_EXTRA = 2;
  localparam int REF_NEED  = 2;
endpackage

// File: rtl/sdram_gap_timer.sv
module sdram_gap_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mark_i,
  output logic [W-1:0] gap_o
);
  localparam logic [W-1:0] SAT = '1;
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt;

  // distance in clocks to the last mark, saturating
  always_ff @(posedge clk) begin
    if (rst)             cnt <= SAT;
    else if (mark_i)     cnt <= ONE;
    else if (cnt != SAT) cnt <= cnt + ONE;
  end

  assign gap_o = mark_i ? '0 : cnt;
endmodule

// File: rtl/sdram_init_tracker.sv
module sdram_init_tracker #(
  parameter int PAUSE_CYC = 20000,
  parameter int REF_NEED  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_i,
  output logic pause_done_o,
  output logic init_done_o
);
  localparam int PW = $clog2(PAUSE_CYC + 1);
  localparam int RW = $clog2(REF_NEED + 1);

  logic [PW-1:0] pcnt;
  logic [RW-1:0] rcnt;

  assign pause_done_o = (pcnt == PW'(PAUSE_CYC));
  assign init_done_o  = (rcnt == RW'(REF_NEED));

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt <= '0;
      rcnt <= '0;
    end else begin
      if (!pause_done_o) pcnt <= pcnt + PW'(1);
      if (ref_i && pause_done_o && !init_done_o) rcnt <= rcnt + RW'(1);
    end
  end
endmodule

// File: rtl/sdram_cmd_spacing_mon.sv
module sdram_cmd_spacing_mon
  import sdram_mon_pkg::*;
#(
  parameter int PAUSE_CYC = 20000,
  parameter int GAP_W     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cke_i,
  input  logic [2:0]        cmd_i,
  input  logic [1:0]        cl_i,
  input  logic              wr_last_i,
  output logic [RULE_N-1:0] viol_o,
  output logic              viol_any_o
);
  logic              cke_q;
  sdr_cmd_e          cmd_raw, cmd_v;
  logic [GAP_W-1:0]  wr_gap, lmr_gap, dal_min;
  logic              pause_done, init_done;
  logic [RULE_N-1:0] hit;

  assign cmd_raw = sdr_cmd_e'(cmd_i);
  assign cmd_v   = cke_q ? cmd_raw : CMD_NOP;

  always_ff @(posedge clk) begin
    if (rst) cke_q <= 1'b1;
    else     cke_q <= cke_i;
  end

  sdram_gap_timer #(.W(GAP_W)) u_wr_gap (
    .clk(clk), .rst(rst), .mark_i(wr_last_i), .gap_o(wr_gap)
  );

  sdram_gap_timer #(.W(GAP_W)) u_lmr_gap (
    .clk(clk), .rst(rst), .mark_i(cmd_v == CMD_LMR), .gap_o(lmr_gap)
  );

  sdram_init_tracker #(.PAUSE_CYC(PAUSE_CYC), .REF_NEED(REF_NEED)) u_init (
    .clk(clk), .rst(rst), .ref_i(cmd_v == CMD_REF),
    .pause_done_o(pause_done), .init_done_o(init_done)
  );

  always_comb begin
    case (cl_i)
      2'd1:    dal_min = GAP_W'(1 + DAL_EXTRA);
      2'd2:    dal_min = GAP_W'(2 + DAL_EXTRA);
      default: dal_min = GAP_W'(3 + DAL_EXTRA);
    endcase
  end

  always_comb begin
    hit = '0;
    hit[RULE_INIT] = (cmd_v != CMD_NOP) && !init_done &&
                     !((cmd_v == CMD_REF) && pause_done);
    hit[RULE_MRD]  = ((cmd_v == CMD_ACT) || (cmd_v == CMD_REF)) &&
                     (lmr_gap < GAP_W'(MRD_MIN));
    hit[RULE_RDL]  = (cmd_v == CMD_PRE) && (wr_gap < GAP_W'(RDL_MIN));
    hit[RULE_DAL]  = (cmd_v == CMD_ACT) && (wr_gap < dal_min);
    hit[RULE_BDL]  = (cmd_v == CMD_BST) && (wr_gap == '0);
    hit[RULE_CDL]  = ((cmd_v == CMD_RD) || (cmd_v == CMD_WR)) && (wr_gap == '0);
    hit[RULE_CKE]  = !cke_q && (cmd_raw != CMD_NOP);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      viol_o     <= '0;
      viol_any_o <= 1'b0;
    end else begin
      viol_o     <= viol_o | hit;
      viol_any_o <= |(viol_o | hit);
    end
  end
endmodule

// File: rtl/sdram_mon_chk.sv
module sdram_mon_chk (
  input logic       clk,
  input logic       rst,
  input logic       cke_i,
  input logic [2:0] cmd_i,
  input logic       wr_last_i,
  input logic [6:0] viol_o,
  input logic       viol_any_o
);
  p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((viol_o & $past(viol_o)) == $past(viol_o)));

  p_any_r9: assert property (@(posedge clk) disable iff (rst)
    viol_any_o == (|viol_o));

  p_reset_r9: assert property (@(posedge clk)
    rst |=> (viol_o == 7'd0 && !viol_any_o));

  p_nop_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (cmd_i == 3'd0) |=> (viol_o == $past(viol_o)));

  p_cke_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(cke_i) && cmd_i != 3'd0) |=> viol_o[6]);

  p_cdl_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cke_i) && wr_last_i &&
     (cmd_i == 3'd2 || cmd_i == 3'd3)) |=> viol_o[5]);

  p_bdl_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cke_i) && wr_last_i && cmd_i == 3'd7) |=> viol_o[4]);
endmodule

bind sdram_cmd_spacing_mon sdram_mon_chk u_chk (.*);

// File: tb/tb_sdram_cmd_spacing_mon.sv
`timescale 1ns/1ps
module tb_sdram_cmd_spacing_mon;
  localparam int PAUSE = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cke = 1'b1;
  logic [2:0] cmd = 3'd0;
  logic [1:0] cl  = 2'd3;
  logic       wl  = 1'b0;
  logic [6:0] viol_o;
  logic       viol_any_o;

  int errors = 0, checks = 0;
  bit finished = 0;

  int n, last_wr, last_lmr, nref;
  bit ckep;
  logic [6:0] exp_v;

  always #2.5 clk = ~clk;

  sdram_cmd_spacing_mon #(.PAUSE_CYC(PAUSE), .GAP_W(4)) dut (
    .clk(clk), .rst(rst), .cke_i(cke), .cmd_i(cmd), .cl_i(cl),
    .wr_last_i(wl), .viol_o(viol_o), .viol_any_o(viol_any_o)
  );

  task automatic check(input string tag);
    checks++;
    if (viol_o !== exp_v || viol_any_o !== (|exp_v)) begin
      errors++;
      $display("FAIL %s cycle %0d: viol=%b any=%b expected viol=%b any=%b",
               tag, n, viol_o, viol_any_o, exp_v, |exp_v);
    end
  endtask

  task automatic model(input bit k, input int c, input bit w);
    int ce, gw, gl, dmin;
    logic [6:0] h;
    ce = ckep ? c : 0;
    gw = w ? 0 : n - last_wr;
    gl = n - last_lmr;
    dmin = (cl == 2'd1) ? 3 : (cl == 2'd2) ? 4 : 5;
    h = '0;
    if (ce != 0 && nref < 2 && !(ce == 5 && n >= PAUSE)) h[0] = 1'b1;
    if ((ce == 1 || ce == 5) && gl < 2) h[1] = 1'b1;
    if (ce == 4 && gw < 2) h[2] = 1'b1;
    if (ce == 1 && gw < dmin) h[3] = 1'b1;
    if (ce == 7 && gw < 1) h[4] = 1'b1;
    if ((ce == 2 || ce == 3) && gw < 1) h[5] = 1'b1;
    if (!ckep && c != 0) h[6] = 1'b1;
    exp_v |= h;
    if (w) last_wr = n;
    if (ce == 6) last_lmr = n;
    if (ce == 5 && n >= PAUSE && nref < 2) nref++;
    ckep = k;
    n++;
  endtask

  task automatic step(input bit k, input logic [2:0] c, input bit w, input string tag);
    cke = k; cmd = c; wl = w;
    model(k, int'(c), w);
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  task automatic do_reset();
    rst = 1'b1; cke = 1'b1; cmd = 3'd0; wl = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    n = 0; last_wr = -1000; last_lmr = -1000; nref = 0; ckep = 1; exp_v = '0;
    check("R9 reset");
  endtask

  task automatic init_seq();
    for (int i = 0; i < PAUSE; i++) step(1, 3'd0, 0, "R7 pause");
    step(1, 3'd5, 0, "R7 refresh1");
    step(1, 3'd5, 0, "R7 refresh2");
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    // legal flow: R7 init, R1 back-to-back column commands, R2 legal gap
    do_reset();
    init_seq();
    step(1, 3'd2, 0, "R1");
    step(1, 3'd2, 0, "R1");
    step(1, 3'd3, 0, "R1");
    step(1, 3'd3, 0, "R1");
    step(1, 3'd6, 0, "R2 lmr");
    step(1, 3'd0, 0, "R2");
    step(1, 3'd1, 0, "R2 gap2 ok");
    step(1, 3'd0, 1, "R10 nop with wr_last");
    step(1, 3'd0, 0, "R10");

    // R7 early refresh and early command
    do_reset();
    step(1, 3'd0, 0, "R7");
    step(1, 3'd5, 0, "R7 early refresh");
    for (int i = 0; i < PAUSE; i++) step(1, 3'd0, 0, "R7");
    step(1, 3'd5, 0, "R7 refresh after pause");
    step(1, 3'd1, 0, "R7 active after one refresh");

    // R2 mode load then activate next clock
    do_reset();
    init_seq();
    step(1, 3'd6, 0, "R2 lmr");
    step(1, 3'd1, 0, "R2 gap1");
    step(1, 3'd0, 0, "R9 sticky");

    // R3 precharge after write end
    do_reset();
    init_seq();
    step(1, 3'd3, 1, "R3 wr end");
    step(1, 3'd0, 0, "R3");
    step(1, 3'd4, 0, "R3 gap2 ok");
    step(1, 3'd3, 1, "R3 wr end");
    step(1, 3'd4, 0, "R3 gap1");

    // R4 activate after write end, for each CL
    do_reset();
    init_seq();
    cl = 2'd2;
    step(1, 3'd0, 1, "R4 cl2");
    for (int i = 0; i < 3; i++) step(1, 3'd0, 0, "R4");
    step(1, 3'd1, 0, "R4 cl2 gap4 ok");
    cl = 2'd1;
    step(1, 3'd0, 1, "R4 cl1");
    step(1, 3'd0, 0, "R4");
    step(1, 3'd0, 0, "R4");
    step(1, 3'd1, 0, "R4 cl1 gap3 ok");
    cl = 2'd3;
    step(1, 3'd0, 1, "R4 cl3");
    for (int i = 0; i < 3; i++) step(1, 3'd0, 0, "R4");
    step(1, 3'd1, 0, "R4 cl3 gap4");
    cl = 2'd0;
    do_reset();
    init_seq();
    step(1, 3'd0, 1, "R4 cl0");
    for (int i = 0; i < 4; i++) step(1, 3'd0, 0, "R4");
    step(1, 3'd1, 0, "R4 cl0 gap5 ok");
    cl = 2'd3;

    // R5 burst stop, R6 column command in the write end clock
    do_reset();
    init_seq();
    step(1, 3'd3, 1, "R5 wr end");
    step(1, 3'd7, 0, "R5 gap1 ok");
    step(1, 3'd7, 1, "R5 gap0");
    step(1, 3'd2, 1, "R6 gap0");

    // R8 clock disable window; ignored mode load leaves no timer
    do_reset();
    init_seq();
    step(0, 3'd0, 0, "R8 cke low");
    step(1, 3'd6, 0, "R8 cmd during exit");
    step(1, 3'd1, 0, "R8 ignored lmr no R2");
    step(1, 3'd0, 0, "R8");

    // concurrent R2 and R4 on one activate
    do_reset();
    init_seq();
    step(1, 3'd6, 1, "R2 R4 setup");
    step(1, 3'd1, 0, "R2 R4 same cycle");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule